// File: doc/BRIEF.md
# APB Slave Word Memory with Range Error

This block is an APB completer that holds a small array of 32 words, each 32 bits wide. A requester issues single read or write transfers over the usual APB signal set. An explicit four-phase controller (idle, setup, access, transfer) steps through each transfer. It adds one wait state, then raises `pready` for a single cycle to complete the transfer.

The address bus is wider than the five bits needed to index the array, so addresses past the last word can reach the block. Such an access still completes with normal timing, but `pslverr` is raised with `pready`. A write to such an address leaves every word untouched, and a read from one returns zero. A synchronous active-low reset clears the array, the read data register and the response signals.

Top module: `apb_mem_slave`

## Requirements
- R1: While `presetn` is sampled low at a rising `pclk` edge, the block returns to idle at that edge: `pready` and `pslverr` go low, `prdata` goes to zero and all 32 words are cleared to zero.
- R2: A write to address A (0 to 31) stores `pwdata` in word A. A later read from A returns that value on `prdata` in the completing cycle.
- R3: Each transfer takes three cycles. In the setup cycle `psel`=1 and `penable`=0. The next cycle is the first access cycle, with `psel`=1, `penable`=1 and `pready`=0. In the cycle after that `pready`=1. `pready` is high for exactly one cycle per transfer.
- R4: `pslverr` is high only while `pready` is high. In the completing cycle it is 1 exactly when `paddr` is 32 or above (unsigned).
- R5: A write to an address of 32 or above modifies no word of the array.
- R6: A read from an address of 32 or above completes with `prdata` equal to zero.
- R7: A transfer starts only when `psel`=1 and `penable`=0 is seen while the controller is idle or has just completed. If `psel` is low, or if `psel` and `penable` are both high without a prior setup cycle, `pready` stays low and no word changes.
- R8: A setup cycle placed directly after the completing cycle, with `psel` held high, starts the next transfer at once. It keeps the same three-cycle timing and gives correct data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Clock; all state changes on its rising edge |
| presetn | input | 1 | Synchronous reset, active low |
| psel | input | 1 | Completer select |
| penable | input | 1 | High in the access cycles of a transfer |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 32 | Word address; only 0 to 31 are backed by storage |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid while `pready` is high on a read |
| pready | output | 1 | Transfer completion, one cycle |
| pslverr | output | 1 | Error response for an out-of-range address |

## Verification
If the phase register is wrong, the error shows on the very next transfer. Either `pready` arrives a cycle early or late, it stays high for two cycles, or it is missing, so it is caught within three cycles of a setup. A wrong captured error flag or word index corrupts `pslverr` or `prdata` in the same completing cycle. A write that escapes the range gate damages storage silently, so it only shows on a later readback. For that reason every out-of-range write batch is followed by a full 32-word read sweep.

// File: rtl/apb_mem_pkg.sv
package apb_mem_pkg;

    localparam int unsigned APB_AW    = 32;
    localparam int unsigned APB_DW    = 32;
    localparam int unsigned MEM_WORDS = 32;

    typedef enum logic [1:0] {
        PH_IDLE     = 2'd0,
        PH_SETUP    = 2'd1,
        PH_ACCESS   = 2'd2,
        PH_TRANSFER = 2'd3
    } phase_e;

    // Per-transfer flags captured when the access cycle is first seen.
    typedef struct packed {
        logic is_write;
        logic bad_addr;
    } xfer_flags_t;

    // Next phase of the transfer controller.
    function automatic phase_e phase_next(phase_e cur, logic sel, logic en);
        phase_e nxt;
        nxt = cur;
        unique case (cur)
            PH_IDLE, PH_TRANSFER: nxt = (sel && !en) ? PH_SETUP : PH_IDLE;
            PH_SETUP: begin
                if (!sel)    nxt = PH_IDLE;
                else if (en) nxt = PH_ACCESS;
                else         nxt = PH_SETUP;
            end
            PH_ACCESS: nxt = PH_TRANSFER;
            default:   nxt = PH_IDLE;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/apb_mem_fsm.sv
module apb_mem_fsm
    import apb_mem_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   sel,
    input  logic   en,
    output phase_e phase,
    output logic   capture,
    output logic   complete
);

    phase_e phase_q;

    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_next(phase_q, sel, en);
    end

    assign phase    = phase_q;
    // First access cycle: latch flags and read data for the next cycle.
    assign capture  = (phase_q == PH_SETUP) && sel && en;
    // Completing cycle: response is presented, write commits at its end.
    assign complete = (phase_q == PH_ACCESS);

endmodule

// File: rtl/apb_mem_range.sv
module apb_mem_range #(
    parameter int unsigned AW    = 32,
    parameter int unsigned DEPTH = 32,
    localparam int unsigned IW   = $clog2(DEPTH)
) (
    input  logic [AW-1:0] addr,
    output logic          in_range,
    output logic [IW-1:0] idx
);

    localparam logic [AW-1:0] LIMIT = AW'(DEPTH);

    assign in_range = (addr < LIMIT);
    assign idx      = addr[IW-1:0];

endmodule

// File: rtl/apb_mem_store.sv
module apb_mem_store #(
    parameter int unsigned DW    = 32,
    parameter int unsigned DEPTH = 32,
    localparam int unsigned IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [DW-1:0] wdata,
    input  logic [IW-1:0] ridx,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] words [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(DEPTH); i++) words[i] <= '0;
        end else if (we) begin
            words[widx] <= wdata;
        end
    end

    assign rdata = words[ridx];

endmodule

// File: rtl/apb_mem_slave.sv
module apb_mem_slave
    import apb_mem_pkg::*;
#(
    parameter int unsigned ADDR_W = APB_AW,
    parameter int unsigned DATA_W = APB_DW,
    parameter int unsigned DEPTH  = MEM_WORDS,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    output logic              pslverr
);

    phase_e            phase;
    logic              capture;
    logic              complete;
    logic              addr_ok;
    logic [IDX_W-1:0]  addr_idx;
    logic [DATA_W-1:0] word_rd;

    xfer_flags_t       flags_q;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] rdata_q;
    logic              wr_en;

    apb_mem_fsm u_fsm (
        .clk      (pclk),
        .rst_n    (presetn),
        .sel      (psel),
        .en       (penable),
        .phase    (phase),
        .capture  (capture),
        .complete (complete)
    );

    apb_mem_range #(.AW(ADDR_W), .DEPTH(DEPTH)) u_range (
        .addr     (paddr),
        .in_range (addr_ok),
        .idx      (addr_idx)
    );

    always_ff @(posedge pclk) begin
        if (!presetn) begin
            flags_q <= '0;
            idx_q   <= '0;
            rdata_q <= '0;
        end else if (capture) begin
            flags_q.is_write <= pwrite;
            flags_q.bad_addr <= !addr_ok;
            idx_q            <= addr_idx;
            if (!pwrite) rdata_q <= addr_ok ? word_rd : '0;
        end
    end

    assign wr_en = complete && flags_q.is_write && !flags_q.bad_addr;

    apb_mem_store #(.DW(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk   (pclk),
        .rst_n (presetn),
        .we    (wr_en),
        .widx  (idx_q),
        .wdata (pwdata),
        .ridx  (addr_idx),
        .rdata (word_rd)
    );

    assign prdata  = rdata_q;
    assign pready  = complete;
    assign pslverr = complete && flags_q.bad_addr;

endmodule

// File: rtl/apb_mem_slave_chk.sv
module apb_mem_slave_chk #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DEPTH  = 32
) (
    input logic              pclk,
    input logic              presetn,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic [ADDR_W-1:0] paddr,
    input logic [DATA_W-1:0] prdata,
    input logic              pready,
    input logic              pslverr
);

    localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(DEPTH);

    // R1: reset sampled low leaves the response idle and data cleared
    p_reset_idle_r1: assert property (@(posedge pclk)
        !presetn |=> (!pready && !pslverr && prdata == '0));

    // R3: completion lasts a single cycle
    p_ready_single_r3: assert property (@(posedge pclk) disable iff (!presetn)
        pready |=> !pready);

    // R3: completion lies inside an access cycle that followed another one
    p_ready_in_access_r3: assert property (@(posedge pclk) disable iff (!presetn)
        pready |-> (psel && penable && $past(psel && penable)));

    // R4: error only alongside completion
    p_err_with_ready_r4: assert property (@(posedge pclk) disable iff (!presetn)
        pslverr |-> pready);

    // R4: error flags exactly the out-of-range addresses
    p_err_range_r4: assert property (@(posedge pclk) disable iff (!presetn)
        pready |-> (pslverr == (paddr >= LIMIT)));

    // R6: out-of-range reads return zero
    p_bad_read_zero_r6: assert property (@(posedge pclk) disable iff (!presetn)
        (pready && !pwrite && pslverr) |-> (prdata == '0));

    // R7: no completion without select in the preceding cycle
    p_no_start_r7: assert property (@(posedge pclk) disable iff (!presetn)
        !psel |=> !pready);

endmodule

bind apb_mem_slave apb_mem_slave_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH)
) u_chk (
    .pclk    (pclk),
    .presetn (presetn),
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .prdata  (prdata),
    .pready  (pready),
    .pslverr (pslverr)
);

// File: tb/apb_mem_slave_tb.sv
module apb_mem_slave_tb;

    logic        pclk = 1'b0;
    logic        presetn = 1'b0;
    logic        psel = 1'b0;
    logic        penable = 1'b0;
    logic        pwrite = 1'b0;
    logic [31:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready;
    logic        pslverr;

    int vectors = 0;
    int fails   = 0;

    always #2 pclk = ~pclk;

    apb_mem_slave u_dut (
        .pclk    (pclk),
        .presetn (presetn),
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .pwdata  (pwdata),
        .prdata  (prdata),
        .pready  (pready),
        .pslverr (pslverr)
    );

    function automatic logic [31:0] pat(int i, bit inv);
        logic [31:0] v;
        v = (32'(i) * 32'h9E37_79B9) ^ 32'h5A5A_0F0F;
        return inv ? ~v : v;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One transfer; returns at the negedge of the completing cycle.
    task automatic xfer(input bit wr, input logic [31:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output logic err);
        @(negedge pclk);
        check("R3 idle before setup", {31'b0, pready}, 32'd0);
        psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d;
        @(negedge pclk);
        check("R3 wait cycle", {31'b0, pready}, 32'd0);
        penable = 1'b1;
        @(negedge pclk);
        check("R3 completion", {31'b0, pready}, 32'd1);
        rd  = prdata;
        err = pslverr;
    endtask

    task automatic go_idle();
        @(negedge pclk);
        check("R3 single-cycle ready", {31'b0, pready}, 32'd0);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic sweep_read(string req, bit inv, bit zero);
        logic [31:0] rd;
        logic        err;
        for (int i = 0; i < 32; i++) begin
            xfer(1'b0, 32'(i), '0, rd, err);
            check(req, rd, zero ? 32'd0 : pat(i, inv));
            check("R4 no error in range", {31'b0, err}, 32'd0);
        end
        go_idle();
    endtask

    initial begin
        logic [31:0] rd;
        logic        err;
        logic [31:0] bad [8];
        bad[0] = 32'd32;        bad[1] = 32'd33;
        bad[2] = 32'd63;        bad[3] = 32'd64;
        bad[4] = 32'd1000;      bad[5] = 32'h8000_0003;
        bad[6] = 32'hFFFF_FFFF; bad[7] = 32'h0001_0005;

        repeat (3) @(negedge pclk);
        check("R1 pready in reset", {31'b0, pready}, 32'd0);
        check("R1 pslverr in reset", {31'b0, pslverr}, 32'd0);
        check("R1 prdata in reset", prdata, 32'd0);
        presetn = 1'b1;

        // R1: array cleared after reset
        sweep_read("R1 word cleared", 1'b0, 1'b1);

        // R2 and R8: back-to-back writes of every word, then back-to-back reads
        for (int i = 0; i < 32; i++) begin
            xfer(1'b1, 32'(i), pat(i, 1'b0), rd, err);
            check("R4 write no error", {31'b0, err}, 32'd0);
        end
        go_idle();
        sweep_read("R2 R8 readback", 1'b0, 1'b0);

        // R2: isolated transfers with inverted pattern
        for (int i = 0; i < 32; i++) begin
            xfer(1'b1, 32'(i), pat(i, 1'b1), rd, err);
            go_idle();
        end
        sweep_read("R2 isolated readback", 1'b1, 1'b0);

        // R4 and R5: out-of-range writes flag an error and change nothing
        for (int k = 0; k < 8; k++) begin
            xfer(1'b1, bad[k], 32'hDEAD_BEEF, rd, err);
            check("R4 bad write error", {31'b0, err}, 32'd1);
        end
        go_idle();
        sweep_read("R5 memory untouched", 1'b1, 1'b0);

        // R6: out-of-range read returns zero even after a nonzero read
        for (int k = 0; k < 8; k++) begin
            xfer(1'b0, 32'd7, '0, rd, err);
            check("R6 prior read", rd, pat(7, 1'b1));
            xfer(1'b0, bad[k], '0, rd, err);
            check("R6 bad read data", rd, 32'd0);
            check("R4 bad read error", {31'b0, err}, 32'd1);
            go_idle();
        end

        // R7: no select, or access without setup, never completes or writes
        @(negedge pclk);
        psel = 1'b0; penable = 1'b1; pwrite = 1'b1; paddr = 32'd3; pwdata = 32'h1234_5678;
        for (int c = 0; c < 4; c++) begin
            @(negedge pclk);
            check("R7 unselected", {31'b0, pready}, 32'd0);
        end
        psel = 1'b1;
        for (int c = 0; c < 4; c++) begin
            @(negedge pclk);
            check("R7 access without setup", {31'b0, pready}, 32'd0);
        end
        psel = 1'b0; penable = 1'b0;
        xfer(1'b0, 32'd3, '0, rd, err);
        check("R7 word unchanged", rd, pat(3, 1'b1));
        go_idle();

        // R1: reset during operation clears the array
        xfer(1'b1, 32'd9, 32'hCAFE_F00D, rd, err);
        go_idle();
        @(negedge pclk);
        presetn = 1'b0;
        repeat (2) @(negedge pclk);
        check("R1 prdata after mid reset", prdata, 32'd0);
        check("R1 pready after mid reset", {31'b0, pready}, 32'd0);
        presetn = 1'b1;
        sweep_read("R1 cleared after mid reset", 1'b0, 1'b1);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge pclk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule